// File: doc/BRIEF.md
# Power Switch Fault Supervisor

This block is the digital decision layer of a protected power switch. It receives fault events that are already synchronized to its clock. These are overtemperature, enable-pin undervoltage, input undervoltage, input overvoltage, overcurrent, short-circuit, start-up timeout, and two FET-health flags (gate-source and gate-drain). For each event it decides four things: whether the switch turns off, whether current limiting is requested instead, whether the fault is stored, and whether the shared fault line is pulled low.

The fault line models an open-drain wire shared by switches connected in parallel. The block drives it through `flt_pull` and reads the wire level back on `flt_in`. If the wire is low while the block itself is not pulling, a neighbour has a fault, and the local switch stays off until the wire is released.

A stored fault is cleared by reset or by the deep-shutdown input `en_sd`. In auto-retry mode a stored fault also clears by itself once a retry interval has run out. The fault windows are counted in clock cycles, and each window length is a parameter.

Top module: `psw_fault_sup`

## Requirements
- R1: With no fault input, no stored fault and `flt_in` high, `sw_en`=1, `flt_pull`=0 and `ilim_act`=0, in both start-up phase (`startup_phase`=1) and steady state (`startup_phase`=0); this is also the state held during reset.
- R2: `ot_evt` stores a fault at the next clock edge; while stored, `sw_en`=0 and `flt_pull`=1, even after `ot_evt` falls.
- R3: `en_uv_evt` or `vin_ov_evt` forces `sw_en`=0 and `flt_pull`=1 in the same cycle, stores nothing, and both outputs recover in the cycle the input falls.
- R4: `vin_uv_evt` forces `sw_en`=0 without storing; it sets `flt_pull`=1 only while `startup_phase`=1 and leaves `flt_pull`=0 in steady state.
- R5: An `oc_evt` run shorter than OC_DLY consecutive cycles has no effect on any output.
- R6: In steady state, `oc_evt` high for OC_DLY consecutive cycles stores a fault at the OC_DLY-th edge (`sw_en`=0, `flt_pull`=1).
- R7: In start-up phase, `oc_evt` high for OC_DLY-1 edges sets `ilim_act`=1 and `flt_pull`=1 while `sw_en` stays 1 and nothing is stored; all three return to idle values when `oc_evt` falls.
- R8: `sc_evt` high for FT_DLY consecutive cycles stores a fault at the FT_DLY-th edge; `su_tmo_evt` stores a fault at the next edge.
- R9: `fet_gs_evt` or `fet_gd_evt` high for FET_DLY consecutive cycles stores a fault at the FET_DLY-th edge, and not one edge earlier.
- R10: `en_sd` clears a stored fault at the next edge. The clear wins over a fault set in the same cycle, and it restarts the retry interval. `sw_en`=0 while `en_sd`=1.
- R11: With `retry_mode`=0 a stored fault persists indefinitely, and `en_uv_evt` pulses do not clear it. With `retry_mode`=1 it clears RETRY_CYC edges after the edge that stored it.
- R12: `flt_in`=0 while `flt_pull`=0 forces `sw_en`=0 without storing; `sw_en` returns to 1 when `flt_in` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ot_evt | input | 1 | Overtemperature event |
| en_uv_evt | input | 1 | Enable-pin undervoltage event |
| vin_uv_evt | input | 1 | Input undervoltage event |
| vin_ov_evt | input | 1 | Input overvoltage event |
| oc_evt | input | 1 | Overcurrent comparator level |
| sc_evt | input | 1 | Short-circuit comparator level |
| su_tmo_evt | input | 1 | Start-up timer expired |
| fet_gs_evt | input | 1 | Gate-source FET health flag |
| fet_gd_evt | input | 1 | Gate-drain FET health flag |
| startup_phase | input | 1 | 1 during start-up/insertion, 0 in steady state |
| en_sd | input | 1 | Deep enable shutdown; clears stored faults |
| retry_mode | input | 1 | 1 selects auto-retry, 0 latch-off |
| flt_in | input | 1 | Level read back from the shared fault wire |
| sw_en | output | 1 | Switch enable |
| flt_pull | output | 1 | 1 pulls the shared fault wire low |
| ilim_act | output | 1 | Current-limit request during start-up |

## Verification
Two events can fall in the same cycle: a deep-shutdown clear and a fresh latched trip. The bench provokes this by raising `ot_evt` and `en_sd` together for one edge. It then requires the stored fault to be gone, which shows up as `sw_en`=1 and `flt_pull`=0 once both inputs drop. A second case starts a new trip just after a deep-shutdown clear in auto-retry mode. The bench then checks that the retry interval is counted again in full from the new trip.

// File: rtl/psw_fault_pkg.sv
package psw_fault_pkg;

  // qualified trip sources that feed the fault store
  typedef struct packed {
    logic ot;
    logic oc;
    logic sc;
    logic su;
    logic gs;
    logic gd;
  } psw_trip_t;

  function automatic logic psw_any_trip(input psw_trip_t t);
    return t.ot | t.oc | t.sc | t.su | t.gs | t.gd;
  endfunction

endpackage

// File: rtl/psw_qual_timer.sv
// Reports a hit once evt_i has been high for DLY consecutive cycles
// (hit is high in the DLY-th cycle and stays high while evt_i holds).
module psw_qual_timer #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic hit_o
);
  localparam int unsigned CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    hit_o  = evt_i && (cnt_q == LAST);
    cnt_en = !evt_i || !hit_o;
    if (!evt_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psw_retry_latch.sv
// Fault store with deep-shutdown clear and optional auto-retry timer.
module psw_retry_latch #(
  parameter int unsigned RETRY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_i,
  output logic lat_o
);
  localparam int unsigned RW = (RETRY_CYC < 2) ? 1 : $clog2(RETRY_CYC);
  localparam logic [RW-1:0] RLAST = RW'(RETRY_CYC - 1);

  logic          lat_q, lat_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          done;

  always_comb begin
    done = lat_q && auto_i && (rcnt_q == RLAST);
    // clear beats set, set beats retry expiry
    if (clr_i)      lat_d = 1'b0;
    else if (set_i) lat_d = 1'b1;
    else if (done)  lat_d = 1'b0;
    else            lat_d = lat_q;

    if (clr_i || !lat_q || !auto_i || done) rcnt_d = '0;
    else                                    rcnt_d = rcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      lat_q  <= lat_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/psw_fault_sup.sv
module psw_fault_sup
  import psw_fault_pkg::*;
#(
  parameter int unsigned OC_DLY    = 16,
  parameter int unsigned FT_DLY    = 3,
  parameter int unsigned FET_DLY   = 2500,
  parameter int unsigned RETRY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ot_evt,
  input  logic en_uv_evt,
  input  logic vin_uv_evt,
  input  logic vin_ov_evt,
  input  logic oc_evt,
  input  logic sc_evt,
  input  logic su_tmo_evt,
  input  logic fet_gs_evt,
  input  logic fet_gd_evt,
  input  logic startup_phase,
  input  logic en_sd,
  input  logic retry_mode,
  input  logic flt_in,
  output logic sw_en,
  output logic flt_pull,
  output logic ilim_act
);
  logic      oc_hit, sc_hit, gs_hit, gd_hit;
  logic      latched;
  logic      soft_off, ext_flt;
  psw_trip_t trip;

  psw_qual_timer #(.DLY(OC_DLY))  u_oc_q (.clk(clk), .rst_n(rst_n), .evt_i(oc_evt),     .hit_o(oc_hit));
  psw_qual_timer #(.DLY(FT_DLY))  u_sc_q (.clk(clk), .rst_n(rst_n), .evt_i(sc_evt),     .hit_o(sc_hit));
  psw_qual_timer #(.DLY(FET_DLY)) u_gs_q (.clk(clk), .rst_n(rst_n), .evt_i(fet_gs_evt), .hit_o(gs_hit));
  psw_qual_timer #(.DLY(FET_DLY)) u_gd_q (.clk(clk), .rst_n(rst_n), .evt_i(fet_gd_evt), .hit_o(gd_hit));

  always_comb begin
    trip.ot = ot_evt;
    trip.oc = oc_hit && !startup_phase;
    trip.sc = sc_hit;
    trip.su = su_tmo_evt;
    trip.gs = gs_hit;
    trip.gd = gd_hit;
  end

  psw_retry_latch #(.RETRY_CYC(RETRY_CYC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .set_i(psw_any_trip(trip)), .clr_i(en_sd), .auto_i(retry_mode),
    .lat_o(latched)
  );

  always_comb begin
    ilim_act = oc_hit && startup_phase;
    soft_off = en_uv_evt || vin_ov_evt || vin_uv_evt;
    flt_pull = latched || en_uv_evt || vin_ov_evt ||
               (vin_uv_evt && startup_phase) || ilim_act;
    ext_flt  = !flt_in && !flt_pull;
    sw_en    = !(latched || soft_off || ext_flt || en_sd);
  end
endmodule

// File: rtl/psw_fault_sup_chk.sv
module psw_fault_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic ot_evt,
  input logic en_uv_evt,
  input logic vin_ov_evt,
  input logic oc_evt,
  input logic startup_phase,
  input logic en_sd,
  input logic retry_mode,
  input logic flt_in,
  input logic sw_en,
  input logic flt_pull,
  input logic ilim_act,
  input logic fault_lat
);
  AST_OT_TURNS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_evt && !en_sd) |=> !sw_en); // R2
  AST_PULL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_pull && !fault_lat) |-> (en_uv_evt || vin_ov_evt || startup_phase)); // R4
  AST_ILIM_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_act |-> (startup_phase && oc_evt)); // R7
  AST_SD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_sd |=> !fault_lat); // R10
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_lat && !retry_mode && !en_sd) |=> fault_lat); // R11
  AST_PEER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_in && !flt_pull) |-> !sw_en); // R12
endmodule

bind psw_fault_sup psw_fault_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ot_evt(ot_evt), .en_uv_evt(en_uv_evt),
  .vin_ov_evt(vin_ov_evt), .oc_evt(oc_evt), .startup_phase(startup_phase),
  .en_sd(en_sd), .retry_mode(retry_mode), .flt_in(flt_in), .sw_en(sw_en),
  .flt_pull(flt_pull), .ilim_act(ilim_act), .fault_lat(latched)
);

// File: tb/psw_fault_sup_test.sv
module psw_fault_sup_test;
  localparam int OC_DLY = 16, FT_DLY = 3, FET_DLY = 2500, RETRY_CYC = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ot_evt = 0, en_uv_evt = 0, vin_uv_evt = 0, vin_ov_evt = 0, oc_evt = 0;
  logic sc_evt = 0, su_tmo_evt = 0, fet_gs_evt = 0, fet_gd_evt = 0;
  logic startup_phase = 0, en_sd = 0, retry_mode = 0, peer_pull = 0;
  logic flt_in, sw_en, flt_pull, ilim_act;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;
  assign flt_in = !(flt_pull || peer_pull);

  psw_fault_sup #(.OC_DLY(OC_DLY), .FT_DLY(FT_DLY), .FET_DLY(FET_DLY),
                  .RETRY_CYC(RETRY_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ot_evt(ot_evt), .en_uv_evt(en_uv_evt),
    .vin_uv_evt(vin_uv_evt), .vin_ov_evt(vin_ov_evt), .oc_evt(oc_evt),
    .sc_evt(sc_evt), .su_tmo_evt(su_tmo_evt), .fet_gs_evt(fet_gs_evt),
    .fet_gd_evt(fet_gd_evt), .startup_phase(startup_phase), .en_sd(en_sd),
    .retry_mode(retry_mode), .flt_in(flt_in), .sw_en(sw_en),
    .flt_pull(flt_pull), .ilim_act(ilim_act));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect3(input string req, input logic e_sw, input logic e_pull, input logic e_il);
    #0.5;
    n_chk++;
    if (sw_en !== e_sw || flt_pull !== e_pull || ilim_act !== e_il) begin
      n_bad++;
      $display("FAIL %s: sw_en/flt_pull/ilim_act = %b%b%b expected %b%b%b",
               req, sw_en, flt_pull, ilim_act, e_sw, e_pull, e_il);
    end
  endtask

  task automatic sd_pulse;
    en_sd = 1; tick(1); en_sd = 0;
  endtask

  task automatic t_idle;
    startup_phase = 0; expect3("R1 steady", 1, 0, 0);
    startup_phase = 1; expect3("R1 start-up", 1, 0, 0);
    startup_phase = 0;
  endtask

  task automatic t_ot;
    ot_evt = 1; tick(1); ot_evt = 0;
    expect3("R2 ot stored", 0, 1, 0);
    tick(5); expect3("R2 ot held", 0, 1, 0);
    en_sd = 1; tick(1); expect3("R10 off during en_sd", 0, 0, 0);
    en_sd = 0; expect3("R10 cleared", 1, 0, 0);
  endtask

  task automatic t_soft;
    en_uv_evt = 1; expect3("R3 en_uv", 0, 1, 0);
    tick(3); en_uv_evt = 0; expect3("R3 en_uv gone", 1, 0, 0);
    vin_ov_evt = 1; expect3("R3 vin_ov", 0, 1, 0);
    tick(3); vin_ov_evt = 0; expect3("R3 vin_ov gone", 1, 0, 0);
  endtask

  task automatic t_uv;
    startup_phase = 1; vin_uv_evt = 1; expect3("R4 uv start-up", 0, 1, 0);
    startup_phase = 0; expect3("R4 uv steady", 0, 0, 0);
    tick(2); vin_uv_evt = 0; expect3("R4 uv gone", 1, 0, 0);
  endtask

  task automatic t_oc;
    oc_evt = 1; tick(OC_DLY - 1); oc_evt = 0;
    expect3("R5 transient oc", 1, 0, 0);
    tick(2); expect3("R5 transient after", 1, 0, 0);
    oc_evt = 1; tick(OC_DLY - 1); expect3("R6 oc one short", 1, 0, 0);
    tick(1); oc_evt = 0; expect3("R6 oc breaker", 0, 1, 0);
    sd_pulse();
    startup_phase = 1; oc_evt = 1; tick(OC_DLY - 2);
    expect3("R7 before limit", 1, 0, 0);
    tick(1); expect3("R7 limiting", 1, 1, 1);
    tick(5); expect3("R7 no store", 1, 1, 1);
    oc_evt = 0; expect3("R7 released", 1, 0, 0);
    startup_phase = 0;
  endtask

  task automatic t_sc_su;
    sc_evt = 1; tick(FT_DLY - 1); expect3("R8 sc one short", 1, 0, 0);
    tick(1); sc_evt = 0; expect3("R8 sc trip", 0, 1, 0);
    sd_pulse();
    su_tmo_evt = 1; tick(1); su_tmo_evt = 0; expect3("R8 start-up timeout", 0, 1, 0);
    sd_pulse(); expect3("R8 cleared", 1, 0, 0);
  endtask

  task automatic t_fet;
    fet_gs_evt = 1; tick(FET_DLY - 1); expect3("R9 gs one short", 1, 0, 0);
    tick(1); fet_gs_evt = 0; expect3("R9 gs trip", 0, 1, 0);
    sd_pulse();
    fet_gd_evt = 1; tick(FET_DLY - 1); expect3("R9 gd one short", 1, 0, 0);
    tick(1); fet_gd_evt = 0; expect3("R9 gd trip", 0, 1, 0);
    sd_pulse();
  endtask

  task automatic t_latchoff;
    retry_mode = 0; ot_evt = 1; tick(1); ot_evt = 0;
    tick(200); expect3("R11 latch-off holds", 0, 1, 0);
    en_uv_evt = 1; tick(3); en_uv_evt = 0;
    expect3("R11 shallow enable drop keeps fault", 0, 1, 0);
    sd_pulse(); expect3("R10 deep clear", 1, 0, 0);
  endtask

  task automatic t_retry;
    retry_mode = 1; ot_evt = 1; tick(1); ot_evt = 0;
    tick(RETRY_CYC - 1); expect3("R11 retry not yet", 0, 1, 0);
    tick(1); expect3("R11 retry expiry", 1, 0, 0);
    ot_evt = 1; tick(1); ot_evt = 0; tick(40);
    sd_pulse(); expect3("R10 clear in retry", 1, 0, 0);
    ot_evt = 1; tick(1); ot_evt = 0;
    tick(RETRY_CYC - 1); expect3("R10 retry restarted", 0, 1, 0);
    tick(1); expect3("R10 full interval", 1, 0, 0);
    retry_mode = 0;
  endtask

  task automatic t_same_cycle;
    ot_evt = 1; en_sd = 1; tick(1); ot_evt = 0; en_sd = 0;
    expect3("R10 clear beats set", 1, 0, 0);
  endtask

  task automatic t_peer;
    peer_pull = 1; expect3("R12 peer fault", 0, 0, 0);
    tick(3); peer_pull = 0; expect3("R12 peer released", 1, 0, 0);
  endtask

  initial begin
    #1; expect3("R1 reset", 1, 0, 0);
    tick(3); rst_n = 1; tick(1);
    t_idle(); t_ot(); t_soft(); t_uv(); t_oc(); t_sc_su();
    t_fet(); t_latchoff(); t_retry(); t_same_cycle(); t_peer();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule